// File: doc/BRIEF.md
# Prescaled Timer Counter with Access-Driven Flag Clearing

This block is a free-running 16-bit timer counter for a microcontroller-style peripheral. A 6-bit prescaler divides the bus clock. The counter advances once per prescaled period. The prescaler also produces a one-cycle divide-by-64 tick for a neighbouring pulse accumulator.

A control register sets four things:
- a master run bit;
- whether the timer halts while the chip is in wait mode;
- whether it halts while the chip is in debug mode;
- which flag-clearing scheme is active.

The block holds an overflow flag and a bank of per-channel event flags. The channels' capture and compare logic lives elsewhere. That logic reports its events and its register accesses to this block through strobes.

In the default scheme, software clears a flag by writing one to its bit. In the quick-clear scheme, the flags are cleared as a side effect of ordinary accesses:
- reading a channel's capture value or writing its compare value clears that channel's flag;
- touching either counter byte clears the overflow flag;
- touching the accumulator count makes the block emit a clear pulse toward the accumulator flags.

Counter writes take effect only in the special mode.

Top module: `cnt_timer_top`

## Requirements
- R1: The control register at address 0 holds run at bit 7, halt-in-wait at bit 6, halt-in-debug at bit 5 and quick-clear at bit 4. Bits 3:0 read as 0. It resets to 0x00 and can be written at any time.
- R2: While running, the counter advances by one every 2**PSC_LOG2 clocks (default 4). It is visible on `count_val`, and its high byte reads at address 1 and its low byte at address 2.
- R3: The timer runs only when run=1, and not (halt-in-wait=1 and `wait_mode`=1), and not (halt-in-debug=1 and `dbg_mode`=1). Otherwise the counter and the prescaler hold their values. With halt-in-debug=0 the timer keeps running in debug mode.
- R4: `tick64` is a single-cycle pulse that occurs once every 64 running clocks. It is never produced while the timer is halted.
- R5: A write to address 1 or 2 loads that counter byte at the next edge only when `spec_mode`=1. It is ignored when `spec_mode`=0. A load does not reset the prescaler phase, so the first period after it can be short.
- R6: The overflow flag (`ovf_flag`, address 4 bit 7) is set when an increment wraps 0xFFFF to 0x0000. A set in the same cycle as a clear wins.
- R7: Channel flag i (`ch_flags[i]`, address 3 bit i) is set one edge after `ch_event[i]`. A set in the same cycle as a clear wins.
- R8: With quick-clear=0, writing 1 to a bit of address 3, or to bit 7 of address 4, clears that flag. Bits written 0 leave their flags unchanged. Access strobes and counter accesses clear nothing.
- R9: With quick-clear=1, `cap_rd_stb[i]` or `cmp_wr_stb[i]` clears channel flag i, and any read or write of address 1 or 2 clears the overflow flag. Write-one-to-clear writes to addresses 3 and 4 are ignored.
- R10: `acc_flag_clr` is high in the same cycle as `acc_access` when quick-clear=1, and low otherwise.
- R11: `irq` is high when any flag is set. It is forced low while the timer is halted by halt-in-wait with `wait_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| wait_mode | input | 1 | Chip is in wait mode |
| dbg_mode | input | 1 | Chip is in debug mode |
| spec_mode | input | 1 | Special mode; enables counter loads |
| ch_event | input | NCH | Per-channel flag set events |
| cap_rd_stb | input | NCH | Per-channel capture-read strobes |
| cmp_wr_stb | input | NCH | Per-channel compare-write strobes |
| acc_access | input | 1 | Accumulator count accessed |
| count_val | output | 16 | Counter value |
| ovf_flag | output | 1 | Overflow flag |
| ch_flags | output | NCH | Channel flags |
| tick64 | output | 1 | Divide-by-64 tick |
| acc_flag_clr | output | 1 | Clear pulse for accumulator flags |
| irq | output | 1 | Timer interrupt request |

## Verification
Register effects, flag sets and flag clears are due one edge after the strobe. The bench therefore drives each strobe at a falling edge, lets one rising edge pass, and samples at the following falling edge.

`acc_flag_clr`, `irq` and read data are combinational, so they are sampled a nanosecond after the inputs settle, within the same cycle.

Counting rates are checked as differences over a fixed number of rising edges, which makes them independent of the prescaler phase. The short-first-period check locks onto the phase by waiting for a `tick64` pulse and then counts the edges to the next increment.

// File: rtl/cnt_timer_pkg.sv
package cnt_timer_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_CNT_LO = 3'd2,
        REG_CHF    = 3'd3,
        REG_STS    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic run_en;
        logic halt_wait;
        logic halt_dbg;
        logic quick_clr;
    } ctrl_t;

    localparam int PSC_W   = 6;
    localparam int CNT_W   = 16;
    localparam int STS_OVF = 7;

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        return {c.run_en, c.halt_wait, c.halt_dbg, c.quick_clr, 4'b0000};
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
        ctrl_t c;
        c.run_en    = b[7];
        c.halt_wait = b[6];
        c.halt_dbg  = b[5];
        c.quick_clr = b[4];
        return c;
    endfunction

endpackage

// File: rtl/cnt_timer_psc.sv
module cnt_timer_psc
    import cnt_timer_pkg::*;
#(
    parameter int PSC_LOG2 = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic step,
    output logic tick
);
    logic [PSC_W-1:0] psc_q;

    always_ff @(posedge clk) begin
        if (rst)      psc_q <= '0;
        else if (run) psc_q <= psc_q + 1'b1;
    end

    assign step = run & (&psc_q[PSC_LOG2-1:0]);
    assign tick = run & (&psc_q);

    // R3: prescaler frozen while halted
    a_r3_psc_hold: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(psc_q));

    // R4: tick only while running
    a_r4_tick_run: assert property (@(posedge clk) disable iff (rst)
        tick |-> run);

endmodule

// File: rtl/cnt_timer_ctr.sv
module cnt_timer_ctr
    import cnt_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             spec_mode,
    input  logic             ld_hi,
    input  logic             ld_lo,
    input  logic [7:0]       ld_data,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic             do_hi, do_lo;

    assign do_hi = spec_mode & ld_hi;
    assign do_lo = spec_mode & ld_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (do_hi || do_lo) begin
            if (do_hi) cnt_q[15:8] <= ld_data;
            if (do_lo) cnt_q[7:0]  <= ld_data;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wrap = step & ~do_hi & ~do_lo & (&cnt_q);
    assign cnt  = cnt_q;

    // R5: loads outside special mode change nothing beyond a normal step
    a_r5_ignore_normal: assert property (@(posedge clk) disable iff (rst)
        (!spec_mode && (ld_hi || ld_lo) && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/cnt_timer_flags.sv
module cnt_timer_flags #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ch_set,
    input  logic [NCH-1:0] ch_clr,
    input  logic           ovf_set,
    input  logic           ovf_clr,
    output logic [NCH-1:0] chf,
    output logic           ovf
);
    logic ovf_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)            f_q <= 1'b0;
            else if (ch_set[i]) f_q <= 1'b1;
            else if (ch_clr[i]) f_q <= 1'b0;
        end
        assign chf[i] = f_q;

        // R7: set wins over a same-cycle clear
        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            ch_set[i] |=> f_q);
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_q <= 1'b0;
        else if (ovf_set) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end
    assign ovf = ovf_q;

    // R6: a wrap always leaves the flag set
    a_r6_ovf_set: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf_q);

endmodule

// File: rtl/cnt_timer_top.sv
module cnt_timer_top
    import cnt_timer_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int PSC_LOG2 = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [2:0]     bus_addr,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    input  logic           wait_mode,
    input  logic           dbg_mode,
    input  logic           spec_mode,
    input  logic [NCH-1:0] ch_event,
    input  logic [NCH-1:0] cap_rd_stb,
    input  logic [NCH-1:0] cmp_wr_stb,
    input  logic           acc_access,
    output logic [15:0]    count_val,
    output logic           ovf_flag,
    output logic [NCH-1:0] ch_flags,
    output logic           tick64,
    output logic           acc_flag_clr,
    output logic           irq
);
    ctrl_t            ctrl_q;
    reg_sel_e         sel;
    logic             wait_blk, dbg_blk, run;
    logic             step, wrap;
    logic             hit_cnt, acc_cnt;
    logic [NCH-1:0]   ch_clr;
    logic             ovf_clr;
    logic [CNT_W-1:0] cnt;
    logic [NCH-1:0]   chf;
    logic             ovf;

    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst)                         ctrl_q <= '0;
        else if (bus_wr && sel == REG_CTRL) ctrl_q <= byte_to_ctrl(bus_wdata);
    end

    assign wait_blk = ctrl_q.halt_wait & wait_mode;
    assign dbg_blk  = ctrl_q.halt_dbg  & dbg_mode;
    assign run      = ctrl_q.run_en & ~wait_blk & ~dbg_blk;

    cnt_timer_psc #(.PSC_LOG2(PSC_LOG2)) u_psc (
        .clk (clk),
        .rst (rst),
        .run (run),
        .step(step),
        .tick(tick64)
    );

    cnt_timer_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .spec_mode(spec_mode),
        .ld_hi    (bus_wr && sel == REG_CNT_HI),
        .ld_lo    (bus_wr && sel == REG_CNT_LO),
        .ld_data  (bus_wdata),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    assign hit_cnt = (sel == REG_CNT_HI) || (sel == REG_CNT_LO);
    assign acc_cnt = (bus_rd || bus_wr) && hit_cnt;

    always_comb begin
        if (ctrl_q.quick_clr) begin
            ch_clr  = cap_rd_stb | cmp_wr_stb;
            ovf_clr = acc_cnt;
        end else begin
            ch_clr  = (bus_wr && sel == REG_CHF) ? bus_wdata[NCH-1:0] : '0;
            ovf_clr = bus_wr && sel == REG_STS && bus_wdata[STS_OVF];
        end
    end

    cnt_timer_flags #(.NCH(NCH)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .ch_set (ch_event),
        .ch_clr (ch_clr),
        .ovf_set(wrap),
        .ovf_clr(ovf_clr),
        .chf    (chf),
        .ovf    (ovf)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = ctrl_to_byte(ctrl_q);
            REG_CNT_HI: bus_rdata = cnt[15:8];
            REG_CNT_LO: bus_rdata = cnt[7:0];
            REG_CHF:    bus_rdata = 8'(chf);
            REG_STS:    bus_rdata = {ovf, 7'b0};
            default:    bus_rdata = 8'h00;
        endcase
    end

    assign count_val    = cnt;
    assign ovf_flag     = ovf;
    assign ch_flags     = chf;
    assign acc_flag_clr = ctrl_q.quick_clr & acc_access;
    assign irq          = (ovf | (|chf)) & ~wait_blk;

    // R11: no request while the wait halt is in force
    a_r11_irq_blocked: assert property (@(posedge clk) disable iff (rst)
        wait_blk |-> !irq);

    // R9: quick-clear counter access drops the flag unless a wrap coincides
    a_r9_ovf_quick: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.quick_clr && acc_cnt && !wrap) |=> !ovf_flag);

endmodule

// File: tb/test_cnt_timer_top.sv
module test_cnt_timer_top;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           bus_wr, bus_rd;
    logic [2:0]     bus_addr;
    logic [7:0]     bus_wdata, bus_rdata;
    logic           wait_mode, dbg_mode, spec_mode, acc_access;
    logic [NCH-1:0] ch_event, cap_rd_stb, cmp_wr_stb;
    logic [15:0]    count_val;
    logic           ovf_flag, tick64, acc_flag_clr, irq;
    logic [NCH-1:0] ch_flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cnt_timer_top #(.NCH(NCH), .PSC_LOG2(2)) i_cnt_timer_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wait_mode(wait_mode), .dbg_mode(dbg_mode), .spec_mode(spec_mode),
        .ch_event(ch_event), .cap_rd_stb(cap_rd_stb), .cmp_wr_stb(cmp_wr_stb),
        .acc_access(acc_access), .count_val(count_val), .ovf_flag(ovf_flag),
        .ch_flags(ch_flags), .tick64(tick64), .acc_flag_clr(acc_flag_clr),
        .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load_count(input logic [15:0] v);
        spec_mode = 1'b1;
        bus_write(3'd1, v[15:8]);
        bus_write(3'd2, v[7:0]);
        spec_mode = 1'b0;
    endtask

    task automatic t_reset_ctrl();
        logic [7:0] d;
        bus_read(3'd0, d);
        check("R1 ctrl reset", d, 8'h00);
        check("R1 count reset", count_val, 0);
        bus_write(3'd0, 8'hFF);
        bus_read(3'd0, d);
        check("R1 low nibble reads zero", d, 8'hF0);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_count_rate();
        logic [15:0] c0;
        logic [7:0]  hi, lo;
        bus_write(3'd0, 8'h80);
        c0 = count_val;
        repeat (40) @(negedge clk);
        check("R2 ten steps in forty clocks", 32'(count_val - c0), 10);
        bus_write(3'd0, 8'h00);
        bus_read(3'd1, hi);
        bus_read(3'd2, lo);
        check("R2 bus read of count", {hi, lo}, count_val);
    endtask

    task automatic t_halts();
        logic [15:0] c0;
        bus_write(3'd0, 8'hE0);
        wait_mode = 1'b1;
        c0 = count_val;
        repeat (40) @(negedge clk);
        check("R3 halted in wait", count_val, c0);
        wait_mode = 1'b0; dbg_mode = 1'b1;
        c0 = count_val;
        repeat (40) @(negedge clk);
        check("R3 halted in debug", count_val, c0);
        bus_write(3'd0, 8'h80);
        c0 = count_val;
        repeat (40) @(negedge clk);
        check("R3 runs in debug when bit clear", 32'(count_val - c0), 10);
        dbg_mode = 1'b0;
        bus_write(3'd0, 8'h00);
        c0 = count_val;
        repeat (40) @(negedge clk);
        check("R3 halted when run bit clear", count_val, c0);
    endtask

    task automatic t_tick();
        int n;
        bus_write(3'd0, 8'h80);
        n = 0;
        for (int i = 0; i < 256; i++) begin
            if (tick64) n++;
            @(negedge clk);
        end
        check("R4 four ticks in 256 clocks", n, 4);
        bus_write(3'd0, 8'hC0);
        wait_mode = 1'b1;
        n = 0;
        for (int i = 0; i < 128; i++) begin
            if (tick64) n++;
            @(negedge clk);
        end
        check("R4 no tick while halted", n, 0);
        wait_mode = 1'b0;
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_load();
        logic [15:0] c0;
        c0 = count_val;
        bus_write(3'd1, 8'h12);
        check("R5 write ignored in normal mode", count_val, c0);
        load_count(16'h3456);
        check("R5 special-mode load", count_val, 16'h3456);
        bus_write(3'd0, 8'h80);
        while (!tick64) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        spec_mode = 1'b1;
        bus_write(3'd2, 8'h50);
        spec_mode = 1'b0;
        @(negedge clk);
        check("R5 value held one edge after load", count_val, 16'h3450);
        @(negedge clk);
        check("R5 short first period keeps phase", count_val, 16'h3451);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_overflow();
        load_count(16'hFFFF);
        check("R6 no flag before wrap", ovf_flag, 0);
        bus_write(3'd0, 8'h80);
        repeat (8) @(negedge clk);
        check("R6 flag after wrap", ovf_flag, 1);
        check("R6 count after wrap", count_val, 16'h0001);
        bus_write(3'd0, 8'h00);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        ch_event = 8'h0F;
        @(posedge clk); @(negedge clk);
        ch_event = '0;
        check("R7 events set flags", ch_flags, 8'h0F);
        bus_write(3'd3, 8'h05);
        check("R8 write-one clears only ones", ch_flags, 8'h0A);
        cap_rd_stb = 8'hFF;
        cmp_wr_stb = 8'hFF;
        @(posedge clk); @(negedge clk);
        cap_rd_stb = '0;
        cmp_wr_stb = '0;
        check("R8 strobes ignored", ch_flags, 8'h0A);
        bus_read(3'd1, d);
        check("R8 count read keeps overflow", ovf_flag, 1);
        bus_write(3'd4, 8'h00);
        check("R8 write zero keeps overflow", ovf_flag, 1);
        bus_read(3'd4, d);
        check("R6 status read", d, 8'h80);
        bus_write(3'd4, 8'h80);
        check("R8 write one clears overflow", ovf_flag, 0);
        bus_write(3'd3, 8'hFF);
    endtask

    task automatic t_quick();
        logic [7:0] d;
        bus_write(3'd0, 8'h10);
        ch_event = 8'hFF;
        @(posedge clk); @(negedge clk);
        ch_event = '0;
        cap_rd_stb = 8'h02;
        cmp_wr_stb = 8'h40;
        @(posedge clk); @(negedge clk);
        cap_rd_stb = '0;
        cmp_wr_stb = '0;
        check("R9 capture read and compare write clear", ch_flags, 8'hBD);
        bus_write(3'd3, 8'hFF);
        check("R9 write-one ignored", ch_flags, 8'hBD);
        ch_event = 8'h01;
        cap_rd_stb = 8'h01;
        @(posedge clk); @(negedge clk);
        ch_event = '0;
        cap_rd_stb = '0;
        check("R7 set wins over clear", ch_flags[0], 1);
        load_count(16'hFFFF);
        bus_write(3'd0, 8'h90);
        repeat (8) @(negedge clk);
        bus_write(3'd0, 8'h10);
        check("R9 overflow set before access", ovf_flag, 1);
        bus_write(3'd4, 8'h80);
        check("R9 status write-one ignored", ovf_flag, 1);
        bus_read(3'd2, d);
        check("R9 count read clears overflow", ovf_flag, 0);
    endtask

    task automatic t_acc_irq();
        acc_access = 1'b1;
        #1 check("R10 pulse in quick mode", acc_flag_clr, 1);
        bus_write(3'd0, 8'h00);
        #1 check("R10 no pulse in normal mode", acc_flag_clr, 0);
        acc_access = 1'b0;
        check("R11 irq with flags set", irq, 1);
        bus_write(3'd0, 8'h40);
        wait_mode = 1'b1;
        #1 check("R11 irq blocked in wait halt", irq, 0);
        bus_write(3'd0, 8'h00);
        #1 check("R11 irq in wait without halt bit", irq, 1);
        wait_mode = 1'b0;
        bus_write(3'd3, 8'hFF);
        #1 check("R11 irq low with no flags", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        wait_mode = 1'b0; dbg_mode = 1'b0; spec_mode = 1'b0; acc_access = 1'b0;
        ch_event = '0; cap_rd_stb = '0; cmp_wr_stb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_ctrl();
        t_count_rate();
        t_halts();
        t_tick();
        t_load();
        t_overflow();
        t_w1c();
        t_quick();
        t_acc_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule